// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a timebase with a set of timestamping and event-scheduling channels. A free-running up-counter advances once per prescaler tick. Software picks one of four divisors through a two-bit select. The counter starts from zero when reset is released and rolls over silently at its maximum value, raising an overflow flag. Software can read it but can never load, clear or stop it.

The counter feeds eight channels. Three are capture-only: on a chosen edge of their input pin they store the counter value and raise a flag. Four are compare-only: when the counter reaches the value in their register they raise a flag and can set, clear or toggle an output pin. The eighth channel is a shared channel. A control bit makes it behave either as a capture channel on its own input pin or as a compare channel on its own output pin. Every flag is cleared by writing a one to it. Each flag has an enable bit, and the flag AND its enable forms that source's interrupt request.

Software reaches the block through a flat register file. It has one write port, and its read port is combinational.

Top module: `pcc_timer`

## Requirements
- R1: After reset the counter reads 0, every flag, pin and interrupt request is 0, the prescale select reads 0 (divide by 1) and the shared channel is in capture mode.
- R2: Control bits [1:0] (address 1) select the divisor: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16 system clocks per counter step. The counter steps by exactly +1 on each tick.
- R3: When the counter is at its maximum and a tick arrives, it goes to 0, the overflow flag (flag register, address 2, bit 8) is set, and counting goes on.
- R4: A write to the counter address (address 0) has no effect on the count.
- R5: A new divisor takes effect only at a tick boundary. The period in progress when the select is written completes at the old divisor.
- R6: A capture channel's two-bit edge field (address 4, bits [2j+1:2j] for capture input j, where j=3 is the shared channel) means 0 off, 1 rising, 2 falling, 3 both. On a selected edge the channel stores the count held in the clock cycle in which the new pin level is first sampled, and it sets its flag.
- R7: A compare channel sets its flag in the cycle in which the count becomes equal to its register. Its two-bit action field (address 5, bits [2j+1:2j] for compare output j, where j=4 is the shared channel) applies to the pin at that edge: 0 none, 1 toggle, 2 clear, 3 set.
- R8: Channel k's flag is bit k of address 2 (channels 0-2 capture, 3-6 compare, 7 shared). Writing a 1 to a flag bit clears it. A set event in the same cycle wins over the clear.
- R9: Each interrupt request equals its flag AND the enable bit in the same bit position at address 3.
- R10: Control bit 2 selects the shared channel's role: 0 capture, 1 compare. In capture mode, writes to its register (address 15) are ignored and its output pin holds. In compare mode, its input pin is ignored and its register is writable.
- R11: Writes to a capture-only channel's register (addresses 8 to 10) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_in | input | N_IC+1 | Capture input pins; top bit belongs to the shared channel |
| cmp_out | output | N_OC+1 | Compare output pins; top bit belongs to the shared channel |
| count | output | CNT_W | Current counter value |
| ch_flag | output | N_IC+N_OC+1 | Per-channel event flags |
| ovf_flag | output | 1 | Counter rollover flag |
| ch_irq | output | N_IC+N_OC+1 | Per-channel interrupt requests |
| ovf_irq | output | 1 | Rollover interrupt request |

## Verification
The bench builds the block with an 8-bit counter and the default channel counts. With that width a full counter period is only 256 ticks. This makes it practical to sweep every compare value on one channel, to observe rollover directly, and to measure each divisor over several periods. It also checks every edge mode on every capture-capable input, the full sequence of pin actions, and a divisor change in the middle of a period, all against values the bench derives from the count it reads at the port.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int DATA_W = 16;
  localparam int PRE_W  = 4;

  // register addresses
  localparam int ADR_COUNT = 0;
  localparam int ADR_CTRL  = 1;
  localparam int ADR_FLAG  = 2;
  localparam int ADR_IEN   = 3;
  localparam int ADR_EDGE  = 4;
  localparam int ADR_ACT   = 5;
  localparam int ADR_CH0   = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;

  // last prescaler count value for a given select: divisor minus one
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return PRE_W'(0);
      2'd1:    return PRE_W'(3);
      2'd2:    return PRE_W'(7);
      default: return PRE_W'(15);
    endcase
  endfunction

  function automatic logic edge_hit(input edge_e mode, input logic prev, input logic cur);
    case (mode)
      EDGE_RISE: return !prev && cur;
      EDGE_FALL: return prev && !cur;
      EDGE_BOTH: return prev != cur;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic pin_next(input act_e act, input logic pin);
    case (act)
      ACT_TOGGLE: return !pin;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return pin;
    endcase
  endfunction

endpackage

// File: rtl/pcc_prescaler.sv
module pcc_prescaler
  import pcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_cfg,
  output logic       tick,
  output logic [1:0] sel_act
);

  logic [PRE_W-1:0] pre_cnt;

  // tick on the last count of the active divisor
  assign tick = (pre_cnt == div_last(sel_act));

  // the requested select is adopted only at a tick boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      sel_act <= 2'd0;
    end else if (tick) begin
      pre_cnt <= '0;
      sel_act <= sel_cfg;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap_evt
);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  assign cnt_nxt  = step(count);
  assign wrap_evt = tick && (&count);

  // no load or hold path: only reset and tick touch the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= cnt_nxt;
  end

endmodule

// File: rtl/pcc_capture.sv
module pcc_capture
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [1:0]       edge_mode,
  input  logic             pin,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic             hit
);

  logic prev;

  assign hit = active && edge_hit(edge_e'(edge_mode), prev, pin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      cap_val <= '0;
    end else begin
      prev <= pin;
      if (hit) cap_val <= count;
    end
  end

endmodule

// File: rtl/pcc_compare.sv
module pcc_compare
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [1:0]       act_mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cmp_val,
  output logic             pin,
  output logic             hit
);

  // match fires on the edge at which the count becomes equal
  assign hit = active && tick && (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
      pin     <= 1'b0;
    end else begin
      if (ld)  cmp_val <= ld_val;
      if (hit) pin     <= pin_next(act_e'(act_mode), pin);
    end
  end

endmodule

// File: rtl/pcc_timer.sv
module pcc_timer
  import pcc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_IC   = 3,
  parameter int N_OC   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [15:0]            wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [15:0]            rd_data,
  input  logic [N_IC:0]          cap_in,
  output logic [N_OC:0]          cmp_out,
  output logic [CNT_W-1:0]       count,
  output logic [N_IC+N_OC:0]     ch_flag,
  output logic                   ovf_flag,
  output logic [N_IC+N_OC:0]     ch_irq,
  output logic                   ovf_irq
);

  localparam int NCH  = N_IC + N_OC + 1;
  localparam int NCAP = N_IC + 1;
  localparam int NCMP = N_OC + 1;

  // configuration state
  logic [1:0]          sel_cfg;
  logic                dual_cmp;
  logic [NCH:0]        ien;
  logic [2*NCAP-1:0]   edge_cfg;
  logic [2*NCMP-1:0]   act_cfg;
  logic [NCH:0]        flags;

  // named internal events
  logic                tick;
  logic [1:0]          sel_act;
  logic [CNT_W-1:0]    cnt_nxt;
  logic                wrap_evt;
  logic [NCAP-1:0]     cap_hit;
  logic [NCMP-1:0]     cmp_hit;
  logic [NCH-1:0]      ch_set;
  logic [NCH:0]        flag_clr;
  logic [CNT_W-1:0]    cap_val  [NCAP];
  logic [CNT_W-1:0]    cmp_val  [NCMP];
  logic [CNT_W-1:0]    chan_val [NCH];

  function automatic logic wr_at(input int adr);
    return wr_en && (wr_addr == ADDR_W'(adr));
  endfunction

  pcc_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_cfg (sel_cfg),
    .tick    (tick),
    .sel_act (sel_act)
  );

  pcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count    (count),
    .cnt_nxt  (cnt_nxt),
    .wrap_evt (wrap_evt)
  );

  // capture side: last slot belongs to the shared channel
  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    logic act_c;
    if (j < N_IC) begin : g_fixed
      assign act_c = 1'b1;
    end else begin : g_shared
      assign act_c = !dual_cmp;
    end
    pcc_capture #(.CNT_W(CNT_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (act_c),
      .edge_mode (edge_cfg[2*j +: 2]),
      .pin       (cap_in[j]),
      .count     (count),
      .cap_val   (cap_val[j]),
      .hit       (cap_hit[j])
    );
  end

  // compare side: last slot belongs to the shared channel
  for (genvar j = 0; j < NCMP; j++) begin : g_cmp
    logic act_o;
    logic ld_o;
    if (j < N_OC) begin : g_fixed
      assign act_o = 1'b1;
      assign ld_o  = wr_at(ADR_CH0 + N_IC + j);
    end else begin : g_shared
      assign act_o = dual_cmp;
      assign ld_o  = dual_cmp && wr_at(ADR_CH0 + NCH - 1);
    end
    pcc_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (act_o),
      .act_mode (act_cfg[2*j +: 2]),
      .tick     (tick),
      .cnt_nxt  (cnt_nxt),
      .ld       (ld_o),
      .ld_val   (wr_data[CNT_W-1:0]),
      .cmp_val  (cmp_val[j]),
      .pin      (cmp_out[j]),
      .hit      (cmp_hit[j])
    );
  end

  // channel numbering: captures, then compares, then the shared one
  for (genvar k = 0; k < NCH; k++) begin : g_map
    if (k < N_IC) begin : g_c
      assign ch_set[k]   = cap_hit[k];
      assign chan_val[k] = cap_val[k];
    end else if (k < N_IC + N_OC) begin : g_o
      assign ch_set[k]   = cmp_hit[k-N_IC];
      assign chan_val[k] = cmp_val[k-N_IC];
    end else begin : g_s
      assign ch_set[k]   = cap_hit[N_IC] | cmp_hit[N_OC];
      assign chan_val[k] = dual_cmp ? cmp_val[N_OC] : cap_val[N_IC];
    end
  end

  assign flag_clr = wr_at(ADR_FLAG) ? wr_data[NCH:0] : '0;

  // configuration and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_cfg  <= 2'd0;
      dual_cmp <= 1'b0;
      ien      <= '0;
      edge_cfg <= '0;
      act_cfg  <= '0;
      flags    <= '0;
    end else begin
      if (wr_at(ADR_CTRL)) begin
        sel_cfg  <= wr_data[1:0];
        dual_cmp <= wr_data[2];
      end
      if (wr_at(ADR_IEN))  ien      <= wr_data[NCH:0];
      if (wr_at(ADR_EDGE)) edge_cfg <= wr_data[2*NCAP-1:0];
      if (wr_at(ADR_ACT))  act_cfg  <= wr_data[2*NCMP-1:0];
      // set events take priority over write-one-to-clear
      flags <= (flags & ~flag_clr) | {wrap_evt, ch_set};
    end
  end

  assign ch_flag  = flags[NCH-1:0];
  assign ovf_flag = flags[NCH];
  assign ch_irq   = flags[NCH-1:0] & ien[NCH-1:0];
  assign ovf_irq  = flags[NCH] & ien[NCH];

  // combinational read port
  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      ADR_COUNT: rd_data = DATA_W'(count);
      ADR_CTRL:  rd_data = DATA_W'({dual_cmp, sel_cfg});
      ADR_FLAG:  rd_data = DATA_W'(flags);
      ADR_IEN:   rd_data = DATA_W'(ien);
      ADR_EDGE:  rd_data = DATA_W'(edge_cfg);
      ADR_ACT:   rd_data = DATA_W'(act_cfg);
      default:   rd_data = '0;
    endcase
    for (int k = 0; k < NCH; k++) begin
      if (rd_addr == ADDR_W'(ADR_CH0 + k)) rd_data = DATA_W'(chan_val[k]);
    end
  end

endmodule

// File: rtl/pcc_timer_chk.sv
module pcc_timer_chk
  import pcc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        sel_act,
  input logic              wrap_evt,
  input logic [NCH-1:0]    ch_set,
  input logic [NCH-1:0]    ch_flag,
  input logic              ovf_flag,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              dual_cmp,
  input logic              dual_pin
);

  // R2: each tick advances the count by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + 1'b1));

  // R2, R4: without a tick the count holds, whatever software writes
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R3: rollover clears the count and raises the overflow flag
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&count)) |=> (count == '0) && ovf_flag);

  // R5: the active divisor changes only at a tick boundary
  a_r5_sel_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sel_act));

  // R8: a channel event always leaves its flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_set) |=> ((ch_flag & $past(ch_set)) == $past(ch_set)));

  // R8: a clear write with no competing event clears the written bits
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_FLAG) && ch_set == '0 && !wrap_evt)
    |=> ((ch_flag & $past(wr_data[NCH-1:0])) == '0));

  // R10: in capture mode the shared channel's pin holds
  a_r10_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_cmp |=> $stable(dual_pin));

endmodule

bind pcc_timer pcc_timer_chk #(
  .CNT_W  (CNT_W),
  .NCH    (N_IC + N_OC + 1),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .count    (count),
  .sel_act  (sel_act),
  .wrap_evt (wrap_evt),
  .ch_set   (ch_set),
  .ch_flag  (ch_flag),
  .ovf_flag (ovf_flag),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .dual_cmp (dual_cmp),
  .dual_pin (cmp_out[N_OC])
);

// File: tb/pcc_timer_tb_top.sv
module pcc_timer_tb_top;
  import pcc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int WD_CYCLES  = 190000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;
  logic [3:0]  cap_in;
  logic [4:0]  cmp_out;
  logic [CW-1:0] count;
  logic [7:0]  ch_flag;
  logic        ovf_flag;
  logic [7:0]  ch_irq;
  logic        ovf_irq;

  int n_chk  = 0;
  int n_fail = 0;

  pcc_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_in(cap_in), .cmp_out(cmp_out), .count(count),
    .ch_flag(ch_flag), .ovf_flag(ovf_flag), .ch_irq(ch_irq), .ovf_irq(ovf_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = a[3:0];
    wr_data = d[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[3:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic clr_flags;
    wr(ADR_FLAG, 16'h01FF);
  endtask

  // cycles until the count changes
  task automatic gap(output int g, output int step_ok);
    int c0;
    c0 = int'(count);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (int'(count) == c0);
    step_ok = (int'(count) == ((c0 + 1) % 256)) ? 1 : 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v, v0, v1, c, g, ok, tgt, p;
    int divs[4];
    int acts[5];
    int apin[5];
    divs = '{1, 4, 8, 16};
    acts = '{3, 3, 2, 0, 1};
    apin = '{1, 1, 0, 0, 1};

    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 flags", int'(ch_flag), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 pins", int'(cmp_out), 0);
    chk("R1 irq", int'({ovf_irq, ch_irq}), 0);
    rd(ADR_CTRL, v);
    chk("R1 ctrl", v, 0);
    @(negedge clk);

    // R4: counter write ignored (divide by 1, so one step per clock)
    c = int'(count);
    wr(ADR_COUNT, 16'h0077);
    chk("R4 count after write", int'(count), (c + 1) % 256);

    // R6: every edge mode on every capture-capable input
    for (int m = 0; m < 4; m++) begin
      wr(ADR_EDGE, m * 85);
      for (int j = 0; j < 4; j++) begin
        int ch;
        ch = (j < 3) ? j : 7;
        clr_flags();
        c = int'(count);
        cap_in[j] = 1'b1;
        @(negedge clk);
        chk("R6 rise flag", int'(ch_flag[ch]), (m == 1 || m == 3) ? 1 : 0);
        if (m == 1 || m == 3) begin
          rd(ADR_CH0 + ch, v);
          chk("R6 rise value", v, c);
        end
        clr_flags();
        c = int'(count);
        cap_in[j] = 1'b0;
        @(negedge clk);
        chk("R6 fall flag", int'(ch_flag[ch]), (m == 2 || m == 3) ? 1 : 0);
        if (m == 2 || m == 3) begin
          rd(ADR_CH0 + ch, v);
          chk("R6 fall value", v, c);
        end
      end
    end

    // R11: capture-only register ignores writes
    rd(ADR_CH0, v0);
    wr(ADR_CH0, 16'h0033);
    rd(ADR_CH0, v1);
    chk("R11 capture reg unchanged", v1, v0);

    // R8: set wins over same-cycle clear, then plain clear
    clr_flags();
    wr_en = 1'b1; wr_addr = ADR_FLAG[3:0]; wr_data = 16'h0001;
    cap_in[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 set beats clear", int'(ch_flag[0]), 1);
    clr_flags();
    chk("R8 write one clears", int'(ch_flag[0]), 0);

    // R9: request = flag AND enable
    cap_in[0] = 1'b0;
    @(negedge clk);
    wr(ADR_IEN, 0);
    chk("R9 disabled", int'(ch_irq[0]), 0);
    wr(ADR_IEN, 1);
    chk("R9 enabled", int'(ch_irq[0]), int'(ch_flag[0]));
    wr(ADR_IEN, 16'h00FE);
    chk("R9 mask", int'(ch_irq), int'(ch_flag & 8'hFE));
    wr(ADR_IEN, 0);

    // R10: shared channel in capture mode
    rd(ADR_CH0 + 7, v0);
    wr(ADR_CH0 + 7, 16'h005A);
    rd(ADR_CH0 + 7, v1);
    chk("R10 write ignored in capture mode", v1, v0);
    wr(ADR_ACT, 3 << 8);
    repeat (300) @(negedge clk);
    chk("R10 pin holds in capture mode", int'(cmp_out[4]), 0);
    // R10: shared channel in compare mode
    wr(ADR_CTRL, 4);
    c = int'(count);
    tgt = (c + 12) % 256;
    wr(ADR_CH0 + 7, tgt);
    clr_flags();
    cap_in[3] = ~cap_in[3];
    @(negedge clk);
    chk("R10 input ignored in compare mode", int'(ch_flag[7]), 0);
    rd(ADR_CH0 + 7, v);
    chk("R10 register writable", v, tgt);
    while (!ch_flag[7]) @(negedge clk);
    chk("R10 compare match count", int'(count), tgt);
    chk("R10 compare pin set", int'(cmp_out[4]), 1);

    // R7: sweep every compare value, toggle action
    wr(ADR_ACT, (3 << 8) | 1);
    for (int t = 0; t < 256; t++) begin
      wr(ADR_CH0 + 3, t);
      p = int'(cmp_out[0]);
      clr_flags();
      while (!ch_flag[3]) @(negedge clk);
      chk("R7 match count", int'(count), t);
      chk("R7 toggle pin", int'(cmp_out[0]), 1 - p);
    end

    // R7: action sequence on a second compare channel
    for (int i = 0; i < 5; i++) begin
      wr(ADR_ACT, (3 << 8) | (acts[i] << 2) | 1);
      c = int'(count);
      wr(ADR_CH0 + 4, (c + 10) % 256);
      clr_flags();
      while (!ch_flag[4]) @(negedge clk);
      chk("R7 action pin", int'(cmp_out[1]), apin[i]);
    end

    // R3: rollover
    while (count != 8'hFF) @(negedge clk);
    wr(ADR_FLAG, 16'h0100);
    chk("R3 wrap to zero", int'(count), 0);
    chk("R3 overflow flag", int'(ovf_flag), 1);
    chk("R9 overflow masked", int'(ovf_irq), 0);
    wr(ADR_IEN, 16'h0100);
    chk("R9 overflow request", int'(ovf_irq), 1);
    wr(ADR_FLAG, 16'h0100);
    chk("R8 overflow cleared", int'(ovf_flag), 0);
    wr(ADR_IEN, 0);

    // R2: each divisor
    for (int s = 1; s <= 4; s++) begin
      int sel;
      sel = s % 4;
      wr(ADR_CTRL, sel);
      gap(g, ok);
      gap(g, ok);
      for (int r = 0; r < 3; r++) begin
        gap(g, ok);
        chk("R2 period", g, divs[sel]);
        chk("R2 step of one", ok, 1);
      end
    end

    // R5: switch from 16 to 1 in mid-period
    wr(ADR_CTRL, 3);
    gap(g, ok);
    gap(g, ok);
    gap(g, ok);
    c = int'(count);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == 5) begin
        wr_en = 1'b1; wr_addr = ADR_CTRL[3:0]; wr_data = 16'h0000;
      end else if (g == 6) begin
        wr_en = 1'b0;
      end
    end while (int'(count) == c);
    chk("R5 old period completes", g, 16);
    gap(g, ok);
    chk("R5 new period", g, 1);

    summary();
  end

endmodule